// File: doc/BRIEF.md
# Serial Audio Transmit Interrupt Controller

This block produces the transmit-side interrupt request for a time-division-multiplexed serial audio transmitter working in network mode. It follows the position of the current time slot inside the frame. It keeps three status flags:

- **data-empty**: new sample data is needed.
- **even-data-empty**: new data is needed and the slot that raised it has an even index.
- **underrun**: a slot began while data was still missing.

It reduces the flags and a per-frame last-slot event to one encoded request for the interrupt controller.

The transmitter core supplies a strobe at the start of each slot and a frame-sync strobe on the first slot of every frame. The control logic supplies the following:

- the frame length;
- a per-slot active mask;
- which transmitters are enabled;
- the interrupt enables.

Writes to the per-transmitter data registers and to the dummy slot register are seen as one-cycle strobes. The flags are registered. The request is registered one cycle behind the flags.

Top module: `sai_tx_irq_ctrl`

## Requirements
- R1: Three enables sit at fixed control-register bit positions, all carried on the port `irq_en_ctrl[23:21]`:
  - bit 21 enables the even-slot request;
  - bit 22 enables the normal data request;
  - bit 23 enables the last-slot request.
  The exception enable is the separate input `exc_en`.
- R2: A slot start together with frame sync is slot 0. Every later slot start advances the index by one. After index `frame_len`, the index wraps to 0. Slot 0 and every other even index count as even.
- R3: A slot start whose `slot_mask` bit (indexed by slot number) is 1 sets `tde`. It also sets `tede` when the slot index is even. A slot start whose mask bit is 0 changes no flag.
- R4: A masked-in slot start that finds `tde` already set also sets `tue`.
- R5: `tde`, `tede` and `tue` clear once every transmitter enabled in `tx_enabled` has had its `data_wr` bit pulsed since the flags were last set. The pulses may arrive in any order over several cycles. A write to a disabled transmitter does not count. A slot start in the same cycle wins over the clear.
- R6: A `dummy_wr` pulse clears `tde` and `tede` but leaves `tue` unchanged.
- R7: `irq_req` is registered one cycle after the flags. Its encoding is 0 none, 1 exception, 2 even-slot, 3 normal data, 4 last slot. Sources are ranked in this order:
  1. exception (`tue` and `exc_en`);
  2. even-slot (`tede` and bit 21);
  3. normal data (`tde` and bit 22);
  4. last slot.
- R8: A slot start at index `frame_len`, with bit 23 set, gives `irq_req` = 4 for one cycle, two cycles after the strobe. This happens whatever the slot mask holds, but only when no data request is present in that cycle.
- R9: When `frame_len` is 0 (on-demand mode), no last-slot request is ever produced.
- R10: Clearing an enable bit removes its request on the next registered request, even though the flag stays set.
- R11: After synchronous reset, all flags are 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Strobe at the start of each time slot |
| frame_sync | input | 1 | Marks a slot start as slot 0 |
| frame_len | input | SLOT_W | Index of the last slot; 0 selects on-demand mode |
| slot_mask | input | 2**SLOT_W | Per-slot active mask |
| irq_en_ctrl | input | 3 | Control bits 23:21: last-slot, normal data, even-slot enables |
| exc_en | input | 1 | Exception interrupt enable |
| tx_enabled | input | NUM_TX | Transmitters currently enabled |
| data_wr | input | NUM_TX | Per-transmitter data register write strobes |
| dummy_wr | input | 1 | Dummy slot register write strobe |
| tde | output | 1 | Transmit data empty |
| tede | output | 1 | Even-slot data empty |
| tue | output | 1 | Transmit underrun |
| irq_req | output | 3 | Encoded interrupt request |

## Verification
The bench targets the following corner cases:

- **Last-slot request with every mask bit cleared.** A design that gated this request by the mask would stay silent there.
- **On-demand frame length of zero.** A design that compared the index without checking for zero would give a last-slot request on every slot.
- **Data writes split across cycles, and writes to disabled transmitters.** A design that needed all writes in one cycle would keep the flags set. A design that counted any write would clear them early.
- **Dummy write that must spare the underrun flag.** Covered together with the exception request losing its rank once its enable is off.
- **Slot-index wrap back to an even slot without a fresh frame sync.** This exposes a counter that fails to restart at zero.

// File: rtl/sai_tx_irq_pkg.sv
package sai_tx_irq_pkg;
  typedef enum logic [2:0] {
    REQ_NONE = 3'd0,
    REQ_EXC  = 3'd1,
    REQ_EVEN = 3'd2,
    REQ_DATA = 3'd3,
    REQ_LAST = 3'd4
  } req_e;
  // positions of the enables inside the control word
  localparam int EVEN_EN_BIT = 21;
  localparam int DATA_EN_BIT = 22;
  localparam int LAST_EN_BIT = 23;
endpackage

// File: rtl/sai_slot_tracker.sv
module sai_slot_tracker #(
  parameter int SLOT_W = 5,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_start,
  input  logic              frame_sync,
  input  logic [SLOT_W-1:0] frame_len,
  input  logic [NSLOT-1:0]  slot_mask,
  input  logic              last_en,
  output logic              slot_hit,
  output logic              slot_even,
  output logic              last_hit
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] cur_idx;

  // index of the slot that starts in this cycle
  always_comb begin
    if (frame_sync)              cur_idx = '0;
    else if (slot_q == frame_len) cur_idx = '0;
    else                          cur_idx = slot_q + 1'b1;
  end

  assign slot_hit  = slot_start & slot_mask[cur_idx];
  assign slot_even = ~cur_idx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      last_hit <= 1'b0;
    end else begin
      last_hit <= slot_start && last_en && (frame_len != '0) && (cur_idx == frame_len);
      if (slot_start) slot_q <= cur_idx;
    end
  end

  a_r2_sync_zero: assert property (@(posedge clk) disable iff (rst)
    (slot_start && frame_sync) |=> (slot_q == '0));
  a_r9_last_not_ondemand: assert property (@(posedge clk) disable iff (rst)
    last_hit |-> ($past(frame_len) != '0));
endmodule

// File: rtl/sai_tx_flags.sv
module sai_tx_flags #(
  parameter int NUM_TX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_hit,
  input  logic              slot_even,
  input  logic [NUM_TX-1:0] tx_enabled,
  input  logic [NUM_TX-1:0] data_wr,
  input  logic              dummy_wr,
  output logic              tde,
  output logic              tede,
  output logic              tue
);
  logic [NUM_TX-1:0] wr_seen;
  logic              all_done;

  assign all_done = (|data_wr) && (((wr_seen | data_wr) & tx_enabled) == tx_enabled);

  always_ff @(posedge clk) begin
    if (rst) begin
      tde     <= 1'b0;
      tede    <= 1'b0;
      tue     <= 1'b0;
      wr_seen <= '0;
    end else if (slot_hit) begin
      tde     <= 1'b1;
      if (slot_even) tede <= 1'b1;
      if (tde)       tue  <= 1'b1;
      wr_seen <= '0;
    end else if (all_done) begin
      tde     <= 1'b0;
      tede    <= 1'b0;
      tue     <= 1'b0;
      wr_seen <= '0;
    end else if (dummy_wr) begin
      tde     <= 1'b0;
      tede    <= 1'b0;
      wr_seen <= '0;
    end else begin
      wr_seen <= wr_seen | data_wr;
    end
  end

  a_r3_tede_within_tde: assert property (@(posedge clk) disable iff (rst)
    tede |-> tde);
  a_r4_underrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(tue) |-> $past(tde));
  a_r6_dummy_clears: assert property (@(posedge clk) disable iff (rst)
    (dummy_wr && !slot_hit) |=> (!tde && !tede));
endmodule

// File: rtl/sai_tx_irq_arb.sv
module sai_tx_irq_arb
  import sai_tx_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tde,
  input  logic tede,
  input  logic tue,
  input  logic exc_en,
  input  logic even_en,
  input  logic data_en,
  input  logic last_hit,
  output req_e req_q
);
  req_e req_d;

  always_comb begin
    if (tue && exc_en)        req_d = REQ_EXC;
    else if (tede && even_en) req_d = REQ_EVEN;
    else if (tde && data_en)  req_d = REQ_DATA;
    else if (last_hit)        req_d = REQ_LAST;
    else                      req_d = REQ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= REQ_NONE;
    else     req_q <= req_d;
  end

  a_r7_exc_first: assert property (@(posedge clk) disable iff (rst)
    (tue && exc_en) |=> (req_q == REQ_EXC));
  a_r8_last_origin: assert property (@(posedge clk) disable iff (rst)
    (req_q == REQ_LAST) |-> $past(last_hit));
  a_r10_data_gated: assert property (@(posedge clk) disable iff (rst)
    (req_q == REQ_DATA) |-> $past(data_en && tde));
endmodule

// File: rtl/sai_tx_irq_ctrl.sv
module sai_tx_irq_ctrl
  import sai_tx_irq_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int SLOT_W = 5,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_start,
  input  logic              frame_sync,
  input  logic [SLOT_W-1:0] frame_len,
  input  logic [NSLOT-1:0]  slot_mask,
  input  logic [23:21]      irq_en_ctrl,
  input  logic              exc_en,
  input  logic [NUM_TX-1:0] tx_enabled,
  input  logic [NUM_TX-1:0] data_wr,
  input  logic              dummy_wr,
  output logic              tde,
  output logic              tede,
  output logic              tue,
  output logic [2:0]        irq_req
);
  logic slot_hit, slot_even, last_hit;
  req_e req_q;

  sai_slot_tracker #(.SLOT_W(SLOT_W)) trk_i (
    .clk(clk), .rst(rst), .slot_start(slot_start), .frame_sync(frame_sync),
    .frame_len(frame_len), .slot_mask(slot_mask),
    .last_en(irq_en_ctrl[LAST_EN_BIT]),
    .slot_hit(slot_hit), .slot_even(slot_even), .last_hit(last_hit)
  );

  sai_tx_flags #(.NUM_TX(NUM_TX)) flg_i (
    .clk(clk), .rst(rst), .slot_hit(slot_hit), .slot_even(slot_even),
    .tx_enabled(tx_enabled), .data_wr(data_wr), .dummy_wr(dummy_wr),
    .tde(tde), .tede(tede), .tue(tue)
  );

  sai_tx_irq_arb arb_i (
    .clk(clk), .rst(rst), .tde(tde), .tede(tede), .tue(tue),
    .exc_en(exc_en),
    .even_en(irq_en_ctrl[EVEN_EN_BIT]),
    .data_en(irq_en_ctrl[DATA_EN_BIT]),
    .last_hit(last_hit), .req_q(req_q)
  );

  assign irq_req = req_q;

  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (irq_req == 3'd0 && !tde && !tede && !tue));
endmodule

// File: tb/sai_tx_irq_ctrl_tb_top.sv
module sai_tx_irq_ctrl_tb_top;
  localparam int NUM_TX = 4;
  localparam int SLOT_W = 5;
  localparam int NSLOT  = 1 << SLOT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_start = 1'b0, frame_sync = 1'b0, exc_en = 1'b0, dummy_wr = 1'b0;
  logic [SLOT_W-1:0] frame_len = '0;
  logic [NSLOT-1:0]  slot_mask = '0;
  logic [23:21]      irq_en_ctrl = '0;
  logic [NUM_TX-1:0] tx_enabled = '0, data_wr = '0;
  logic tde, tede, tue;
  logic [2:0] irq_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sai_tx_irq_ctrl #(.NUM_TX(NUM_TX), .SLOT_W(SLOT_W)) dut_i (
    .clk(clk), .rst(rst), .slot_start(slot_start), .frame_sync(frame_sync),
    .frame_len(frame_len), .slot_mask(slot_mask), .irq_en_ctrl(irq_en_ctrl),
    .exc_en(exc_en), .tx_enabled(tx_enabled), .data_wr(data_wr),
    .dummy_wr(dummy_wr), .tde(tde), .tede(tede), .tue(tue), .irq_req(irq_req)
  );

  // {slot_start, frame_sync, data_wr[3:0], dummy_wr, tde, tede, tue, irq[2:0]}
  // frame_len=3, all slots active, transmitters 0 and 1 enabled, all enables on (R1)
  localparam logic [12:0] VEC [16] = '{
    13'b1_1_0000_0_110_000, // slot 0 even (R3)
    13'b0_0_0000_0_110_010, // even request outranks data (R7)
    13'b0_0_0001_0_110_010, // first write only (R5)
    13'b0_0_0010_0_000_010, // second write completes (R5)
    13'b1_0_0000_0_100_000, // slot 1 odd (R2)
    13'b0_0_0000_0_100_011, // normal data request
    13'b1_0_0000_0_111_011, // slot 2 with data missing (R4)
    13'b0_0_0000_0_111_001, // exception first (R7)
    13'b0_0_0000_1_001_001, // dummy spares underrun (R6)
    13'b0_0_0000_0_001_001,
    13'b0_0_0011_0_000_001, // writes clear underrun (R5)
    13'b0_0_0000_0_000_000,
    13'b1_0_0000_0_100_000, // slot 3 = last
    13'b0_0_0000_0_100_011, // data request hides last slot (R8)
    13'b0_0_0011_0_000_011,
    13'b0_0_0000_0_000_000
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic ss, input logic fs,
                      input logic [NUM_TX-1:0] wr, input logic dm);
    slot_start = ss; frame_sync = fs; data_wr = wr; dummy_wr = dm;
    @(posedge clk);
    @(negedge clk);
    slot_start = 1'b0; frame_sync = 1'b0; data_wr = '0; dummy_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 tde", tde, 0); chk("R11 tede", tede, 0);
    chk("R11 tue", tue, 0); chk("R11 irq", irq_req, 0);

    frame_len = 5'd3; slot_mask = '1; tx_enabled = 4'b0011;
    irq_en_ctrl = 3'b111; exc_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10:7], VEC[i][6]);
      chk($sformatf("R3 tde v%0d", i), tde, VEC[i][5]);
      chk($sformatf("R2 tede v%0d", i), tede, VEC[i][4]);
      chk($sformatf("R4 tue v%0d", i), tue, VEC[i][3]);
      chk($sformatf("R7 irq v%0d", i), irq_req, VEC[i][2:0]);
    end

    // R8: last slot with every mask bit clear
    do_reset();
    frame_len = 5'd2; slot_mask = '0; irq_en_ctrl = 3'b100; exc_en = 1'b0;
    step(1, 1, '0, 0);
    step(1, 0, '0, 0);
    step(1, 0, '0, 0);
    chk("R3 masked slot tde", tde, 0);
    step(0, 0, '0, 0);
    chk("R8 last request", irq_req, 4);
    step(0, 0, '0, 0);
    chk("R8 last pulse ends", irq_req, 0);

    // R9: on-demand mode
    frame_len = '0;
    step(1, 1, '0, 0);
    step(0, 0, '0, 0);
    chk("R9 on-demand no last", irq_req, 0);
    step(1, 0, '0, 0);
    step(0, 0, '0, 0);
    chk("R9 on-demand again", irq_req, 0);

    // R10: clearing the data enable
    do_reset();
    frame_len = 5'd3; slot_mask = '1; irq_en_ctrl = 3'b010;
    step(1, 1, '0, 0);
    step(0, 0, '0, 0);
    chk("R10 data request", irq_req, 3);
    irq_en_ctrl = 3'b000;
    step(0, 0, '0, 0);
    chk("R10 request dropped", irq_req, 0);
    chk("R10 flag kept", tde, 1);

    // R2: wrap without frame sync
    frame_len = 5'd1;
    step(0, 0, '0, 1);
    step(1, 1, '0, 0);          // slot 0
    step(0, 0, '0, 1);
    step(1, 0, '0, 0);          // slot 1
    chk("R2 odd slot tede", tede, 0);
    step(0, 0, '0, 1);
    step(1, 0, '0, 0);          // wraps to slot 0
    chk("R2 wrapped even tede", tede, 1);

    // R7 with exception disabled, R5 disabled-transmitter writes
    do_reset();
    frame_len = 5'd3; irq_en_ctrl = 3'b011; exc_en = 1'b0; tx_enabled = 4'b0011;
    step(1, 1, '0, 0);
    step(1, 0, '0, 0);
    chk("R4 underrun set", tue, 1);
    step(0, 0, '0, 0);
    chk("R7 exception disabled", irq_req, 2);
    step(0, 0, 4'b1100, 0);
    chk("R5 disabled writes ignored", tde, 1);
    chk("R5 disabled writes keep tue", tue, 1);
    step(0, 0, 4'b0011, 0);
    chk("R5 enabled writes clear", tde, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule